// File: doc/BRIEF.md
# Shared RAM Host Access Port

This block gives a host processor byte-wide access to the shared RAM of a coprocessor through four registers. The host loads a 16-bit pointer one byte at a time. Each access to the data register then reads or writes the RAM byte at that pointer. When auto-increment is on, the pointer steps forward after every data access. A whole buffer can therefore be moved after a single address load.

A combined status/control register sets two controls toward the coprocessor. One is a run enable that holds the coprocessor in stop while it is low. The other is a one-shot attention request. The same register shows two sticky interrupt flags, which the coprocessor side raises through set inputs. The host clears a flag by writing a 1 to its bit. Either flag raised drives the single host interrupt line.

Every host read has one cycle of latency. `host_rvalid` is high in the cycle after the read strobe, and `host_rdata` is valid while it is high. Only the low `ADDR_W` bits of the pointer index the RAM. All 16 bits are kept and read back.

Top module: `shram_port`

## Requirements
- R1: After reset the pointer is 0x0000. Run, auto-increment, both flags, `cop_run`, `cop_attn`, `host_irq` and `host_rvalid` are all 0.
- R2: A host write to register 0 loads pointer bits 7:0, and a write to register 1 loads pointer bits 15:8. Reads of these registers return the same bytes.
- R3: A write to register 2 stores the byte at RAM index `ptr[ADDR_W-1:0]`. A read of register 2 returns that byte one cycle after the strobe, with `host_rvalid` high.
- R4: While auto-increment is 1, every register-2 access adds one to the pointer after the access. The pointer wraps from 0xFFFF to 0x0000.
- R5: While auto-increment is 0, a register-2 access leaves the pointer unchanged.
- R6: A write to register 3 stores bit 0 as run (driven on `cop_run`) and bit 1 as auto-increment. A read of register 3 returns them at the same positions.
- R7: A register-3 write with bit 2 set makes `cop_attn` high for exactly the next cycle. Bit 2 is not stored and reads as 0.
- R8: `cop_set_int0` sets flag 0, read at register-3 bit 3. `cop_set_int1` sets flag 1, read at bit 4. The flags are sticky, and `host_irq` is high while either is set.
- R9: A register-3 write with a 1 in bit 3 or bit 4 clears that flag, and a 0 leaves it unchanged. A set input in the same cycle as a clear wins, and the flag stays 1.
- R10: Register-3 bits 7:5 always read as 0. A strobe with `host_sel` low has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register select: 0 ptr low, 1 ptr high, 2 data, 3 status/control |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid while host_rvalid |
| host_rvalid | output | 1 | High the cycle after a read strobe |
| cop_set_int0 | input | 1 | Coprocessor side: raise flag 0 |
| cop_set_int1 | input | 1 | Coprocessor side: raise flag 1 |
| cop_run | output | 1 | Run enable toward the coprocessor |
| cop_attn | output | 1 | One-cycle attention pulse toward the coprocessor |
| host_irq | output | 1 | Host interrupt, OR of both flags |

## Verification
The properties assume that `host_sel` marks one complete access per cycle and that `host_reg` and `host_wdata` are meaningful only while it is high. The flag-set inputs are taken as single-cycle events that may arrive at any time, including in the same cycle as a host clear. The stimulus drives every input for a whole cycle from the falling edge. It draws register selects, write data and flag events at random from a fixed seed. It adds directed runs for the pointer wrap, clear-versus-set collisions and zero writes to the flag bits. Data reads are scored only at RAM bytes the bench itself has written, so uninitialised storage is never compared.

// File: rtl/shram_pkg.sv
package shram_pkg;
   localparam int PTR_W  = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      REG_PTR_LO = 2'd0,
      REG_PTR_HI = 2'd1,
      REG_DATA   = 2'd2,
      REG_STAT   = 2'd3
   } reg_sel_e;

   localparam int B_RUN  = 0;
   localparam int B_AINC = 1;
   localparam int B_ATTN = 2;
   localparam int B_INT0 = 3;
   localparam int B_INT1 = 4;
   localparam int N_FLAG = 2;
endpackage

// File: rtl/shram_ptr.sv
module shram_ptr
   import shram_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic              step,
   input  logic [BYTE_W-1:0] wdata,
   output logic [PTR_W-1:0]  ptr
);
   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr_q <= '0;
      else if (ld_lo) ptr_q[BYTE_W-1:0] <= wdata;
      else if (ld_hi) ptr_q[PTR_W-1:BYTE_W] <= wdata;
      else if (step)  ptr_q <= ptr_q + 1'b1;
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/shram_mem.sv
module shram_mem #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (we) store[addr] <= wdata;
      rdata_q <= store[addr];
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
   import shram_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stat,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [N_FLAG-1:0] flag_set,
   output logic              run,
   output logic              ainc,
   output logic              attn,
   output logic [N_FLAG-1:0] flags
);
   logic run_q, ainc_q, attn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         ainc_q <= 1'b0;
         attn_q <= 1'b0;
      end else begin
         attn_q <= wr_stat & wdata[B_ATTN];
         if (wr_stat) begin
            run_q  <= wdata[B_RUN];
            ainc_q <= wdata[B_AINC];
         end
      end
   end

   for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
      logic flag_q;
      logic clr;
      assign clr = wr_stat & wdata[B_INT0 + f];
      always_ff @(posedge clk) begin
         if (!rst_n)           flag_q <= 1'b0;
         else if (flag_set[f]) flag_q <= 1'b1;
         else if (clr)         flag_q <= 1'b0;
      end
      assign flags[f] = flag_q;
   end

   assign run  = run_q;
   assign ainc = ainc_q;
   assign attn = attn_q;
endmodule

// File: rtl/shram_port.sv
module shram_port
   import shram_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_sel,
   input  logic       host_wr,
   input  logic [1:0] host_reg,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       host_rvalid,
   input  logic       cop_set_int0,
   input  logic       cop_set_int1,
   output logic       cop_run,
   output logic       cop_attn,
   output logic       host_irq
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > PTR_W) begin : g_bad_aw
      $error("shram_port: ADDR_W must lie in 1..16");
   end

   logic [PTR_W-1:0]  ptr_q;
   logic [N_FLAG-1:0] flags;
   logic              ainc_q;
   logic [BYTE_W-1:0] mem_q;
   logic              acc, wr_lo, wr_hi, wr_data, wr_stat, data_acc;
   logic [ADDR_W-1:0] mem_addr;
   logic              int0_q, int1_q;

   assign acc      = host_sel;
   assign wr_lo    = acc & host_wr & (host_reg == REG_PTR_LO);
   assign wr_hi    = acc & host_wr & (host_reg == REG_PTR_HI);
   assign wr_data  = acc & host_wr & (host_reg == REG_DATA);
   assign wr_stat  = acc & host_wr & (host_reg == REG_STAT);
   assign data_acc = acc & (host_reg == REG_DATA);
   assign int0_q   = flags[0];
   assign int1_q   = flags[1];

   if (ADDR_W == PTR_W) begin : g_full_idx
      assign mem_addr = ptr_q;
   end else begin : g_part_idx
      assign mem_addr = ptr_q[ADDR_W-1:0];
   end

   shram_ptr u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_lo (wr_lo),
      .ld_hi (wr_hi),
      .step  (data_acc & ainc_q),
      .wdata (host_wdata),
      .ptr   (ptr_q)
   );

   shram_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
      .clk   (clk),
      .we    (wr_data),
      .addr  (mem_addr),
      .wdata (host_wdata),
      .rdata (mem_q)
   );

   shram_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stat  (wr_stat),
      .wdata    (host_wdata),
      .flag_set ({cop_set_int1, cop_set_int0}),
      .run      (cop_run),
      .ainc     (ainc_q),
      .attn     (cop_attn),
      .flags    (flags)
   );

   // read path: capture register bytes at the strobe, RAM byte comes one cycle later
   logic              rd_q;
   logic              rd_data_q;
   logic [BYTE_W-1:0] shadow_q;
   logic [BYTE_W-1:0] shadow_d;

   always_comb begin
      shadow_d = '0;
      case (host_reg)
         REG_PTR_LO: shadow_d = ptr_q[BYTE_W-1:0];
         REG_PTR_HI: shadow_d = ptr_q[PTR_W-1:BYTE_W];
         REG_STAT: begin
            shadow_d[B_RUN]  = cop_run;
            shadow_d[B_AINC] = ainc_q;
            shadow_d[B_INT0] = flags[0];
            shadow_d[B_INT1] = flags[1];
         end
         default: shadow_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q      <= 1'b0;
         rd_data_q <= 1'b0;
         shadow_q  <= '0;
      end else begin
         rd_q      <= acc & ~host_wr;
         rd_data_q <= acc & ~host_wr & (host_reg == REG_DATA);
         if (acc & ~host_wr) shadow_q <= shadow_d;
      end
   end

   assign host_rvalid = rd_q;
   assign host_rdata  = rd_q ? (rd_data_q ? mem_q : shadow_q) : '0;
   assign host_irq    = |flags;
endmodule

// File: rtl/shram_port_chk.sv
module shram_port_chk
   import shram_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        host_sel,
   input logic        host_wr,
   input logic [1:0]  host_reg,
   input logic [7:0]  host_wdata,
   input logic        cop_set_int0,
   input logic        cop_set_int1,
   input logic        cop_attn,
   input logic        host_irq,
   input logic        host_rvalid,
   input logic [15:0] ptr_q,
   input logic        ainc_q,
   input logic        int0_q,
   input logic        int1_q
);
   logic data_acc, stat_wr;
   assign data_acc = host_sel && host_reg == 2'd2;
   assign stat_wr  = host_sel && host_wr && host_reg == 2'd3;

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && ainc_q) |=> ptr_q == $past(ptr_q) + 16'd1);

   // R5
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !ainc_q) |=> $stable(ptr_q));

   // R7
   attn_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && host_wdata[2]) |=> cop_attn);

   // R7
   attn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_wr && host_wdata[2]) |=> !cop_attn);

   // R8
   int0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_set_int0 |=> int0_q);

   // R8
   int1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_set_int1 |=> int1_q);

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_irq) |-> $past(cop_set_int0 || cop_set_int1));

   // R9
   int0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && host_wdata[3] && !cop_set_int0) |=> !int0_q);

   // R9
   int0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int0_q && !(stat_wr && host_wdata[3])) |=> int0_q);

   // R3
   rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && !host_wr) |=> host_rvalid);
endmodule

bind shram_port shram_port_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_sel     (host_sel),
   .host_wr      (host_wr),
   .host_reg     (host_reg),
   .host_wdata   (host_wdata),
   .cop_set_int0 (cop_set_int0),
   .cop_set_int1 (cop_set_int1),
   .cop_attn     (cop_attn),
   .host_irq     (host_irq),
   .host_rvalid  (host_rvalid),
   .ptr_q        (ptr_q),
   .ainc_q       (ainc_q),
   .int0_q       (int0_q),
   .int1_q       (int1_q)
);

// File: tb/sim_shram_port.sv
`timescale 1ns/1ps
module sim_shram_port;
   localparam int AW    = 9;
   localparam int DEPTH = 1 << AW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0, host_wr = 1'b0;
   logic [1:0] host_reg = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       host_rvalid;
   logic       cop_set_int0 = 1'b0, cop_set_int1 = 1'b0;
   logic       cop_run, cop_attn, host_irq;

   always #10 clk = ~clk;

   shram_port #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .cop_set_int0(cop_set_int0),
      .cop_set_int1(cop_set_int1), .cop_run(cop_run), .cop_attn(cop_attn),
      .host_irq(host_irq)
   );

   int total = 0, bad = 0;
   bit done = 0;

   // bench model
   logic [15:0] m_ptr;
   logic        m_run, m_ainc, m_i0, m_i1, m_attn;
   logic [7:0]  m_mem [DEPTH];
   bit          m_known [DEPTH];

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] stat_byte();
      return {3'b000, m_i1, m_i0, 1'b0, m_ainc, m_run};
   endfunction

   // one host cycle; drives at negedge, checks at the following negedge
   task automatic step(input bit sel, input bit wr, input logic [1:0] rg,
                       input logic [7:0] wd, input bit s0, input bit s1);
      logic [7:0] exp_rd;
      bit         known;
      string      tag;
      int         idx;
      idx   = int'(m_ptr[AW-1:0]);
      known = 1;
      case (rg)
         2'd0: begin exp_rd = m_ptr[7:0];  tag = "R2 ptr lo"; end
         2'd1: begin exp_rd = m_ptr[15:8]; tag = "R2 ptr hi"; end
         2'd2: begin exp_rd = m_mem[idx]; known = m_known[idx]; tag = "R3 data"; end
         default: begin exp_rd = stat_byte(); tag = "R6 R10 status"; end
      endcase
      host_sel = sel; host_wr = wr; host_reg = rg; host_wdata = wd;
      cop_set_int0 = s0; cop_set_int1 = s1;
      @(posedge clk);
      // model update
      m_attn = sel && wr && rg == 2'd3 && wd[2];
      if (sel && rg == 2'd2) begin
         if (wr) begin m_mem[idx] = wd; m_known[idx] = 1; end
         if (m_ainc) m_ptr = m_ptr + 16'd1;
      end
      if (sel && wr && rg == 2'd0) m_ptr[7:0]  = wd;
      if (sel && wr && rg == 2'd1) m_ptr[15:8] = wd;
      if (sel && wr && rg == 2'd3) begin
         m_run = wd[0]; m_ainc = wd[1];
         if (wd[3]) m_i0 = 0;
         if (wd[4]) m_i1 = 0;
      end
      if (s0) m_i0 = 1;
      if (s1) m_i1 = 1;
      #1;
      host_sel = 1'b0; cop_set_int0 = 1'b0; cop_set_int1 = 1'b0;
      @(negedge clk);
      check("R3 rvalid", {15'd0, host_rvalid}, {15'd0, sel && !wr});
      if (sel && !wr && known) check(tag, {8'd0, host_rdata}, {8'd0, exp_rd});
      check("R7 attn", {15'd0, cop_attn}, {15'd0, m_attn});
      check("R6 run", {15'd0, cop_run}, {15'd0, m_run});
      check("R8 irq", {15'd0, host_irq}, {15'd0, m_i0 | m_i1});
   endtask

   task automatic rd_status(input logic [7:0] exp, input string req);
      step(1, 0, 2'd3, 8'd0, 0, 0);
      check(req, {8'd0, host_rdata}, {8'd0, exp});
   endtask

   initial begin
      #(20 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_ptr = 0; m_run = 0; m_ainc = 0; m_i0 = 0; m_i1 = 0; m_attn = 0;
      for (int i = 0; i < DEPTH; i++) begin m_known[i] = 0; m_mem[i] = 0; end
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 run", {15'd0, cop_run}, 16'd0);
      check("R1 attn", {15'd0, cop_attn}, 16'd0);
      check("R1 irq", {15'd0, host_irq}, 16'd0);
      check("R1 rvalid", {15'd0, host_rvalid}, 16'd0);
      step(1, 0, 2'd0, 8'd0, 0, 0);
      check("R1 ptr lo", {8'd0, host_rdata}, 16'd0);
      step(1, 0, 2'd1, 8'd0, 0, 0);
      check("R1 ptr hi", {8'd0, host_rdata}, 16'd0);
      rd_status(8'h00, "R1 status");

      // R4 fill whole RAM with auto-increment
      step(1, 1, 2'd3, 8'h03, 0, 0);
      for (int i = 0; i < DEPTH; i++) step(1, 1, 2'd2, 8'(i * 7 + 3), 0, 0);
      step(1, 0, 2'd1, 8'd0, 0, 0);
      check("R4 ptr after fill", {8'd0, host_rdata}, 16'(DEPTH >> 8));

      // R4 wrap 0xFFFF -> 0x0000
      step(1, 1, 2'd0, 8'hFF, 0, 0);
      step(1, 1, 2'd1, 8'hFF, 0, 0);
      step(1, 1, 2'd2, 8'h5A, 0, 0);
      step(1, 0, 2'd0, 8'd0, 0, 0);
      check("R4 wrap lo", {8'd0, host_rdata}, 16'h0000);
      step(1, 0, 2'd1, 8'd0, 0, 0);
      check("R4 wrap hi", {8'd0, host_rdata}, 16'h0000);

      // R5 no advance with auto-increment clear
      step(1, 1, 2'd3, 8'h01, 0, 0);
      step(1, 1, 2'd0, 8'h10, 0, 0);
      step(1, 0, 2'd2, 8'd0, 0, 0);
      step(1, 0, 2'd2, 8'd0, 0, 0);
      step(1, 0, 2'd0, 8'd0, 0, 0);
      check("R5 ptr held", {8'd0, host_rdata}, 16'h0010);

      // R7 attention pulse, bit reads 0
      step(1, 1, 2'd3, 8'h07, 0, 0);
      check("R7 pulse high", {15'd0, cop_attn}, 16'd1);
      step(0, 0, 2'd0, 8'd0, 0, 0);
      check("R7 pulse ended", {15'd0, cop_attn}, 16'd0);
      rd_status(8'h03, "R7 bit2 reads 0");

      // R8 / R9 flags
      step(0, 0, 2'd0, 8'd0, 1, 0);
      rd_status(8'h0B, "R8 int0 set");
      step(1, 1, 2'd3, 8'hE3, 0, 1);
      rd_status(8'h1B, "R9 zero write keeps int0");
      step(1, 1, 2'd3, 8'h0B, 1, 0);
      rd_status(8'h1B, "R9 set beats clear");
      step(1, 1, 2'd3, 8'h1B, 0, 0);
      rd_status(8'h03, "R9 both cleared");
      check("R8 irq low", {15'd0, host_irq}, 16'd0);

      // R10 idle cycles with junk on the bus change nothing
      for (int i = 0; i < 8; i++) step(0, 1, 2'($urandom), 8'($urandom), 0, 0);
      rd_status(8'h03, "R10 deselected ignored");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [7:0] wd;
         r  = int'($urandom % 100);
         wd = 8'($urandom);
         if (r < 35)      step(1, 1, 2'd2, wd, ($urandom % 20) == 0, ($urandom % 20) == 0);
         else if (r < 65) step(1, 0, 2'd2, 8'd0, ($urandom % 20) == 0, 0);
         else if (r < 72) step(1, 1, 2'd0, wd, 0, 0);
         else if (r < 76) step(1, 1, 2'd1, 8'(wd % 2), 0, 0);
         else if (r < 84) step(1, 1, 2'd3, wd, ($urandom % 4) == 0, ($urandom % 4) == 0);
         else if (r < 94) step(1, 0, 2'($urandom), 8'd0, 0, ($urandom % 10) == 0);
         else             step(0, 0, 2'd0, wd, 0, 0);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule